// File: doc/BRIEF.md
# Four-Channel DMA Control and Status Register Bank

This block is the software-visible face of a small DMA controller with four channels. A processor reaches it through a plain 32-bit register port (valid, write, byte address, write data, combinational read data). For every channel it stores a source address, a destination address, a transfer count and a control word. It presents them all to the channel engines, which do the data movement outside this block.

The engines report back with single-cycle finish and error pulses and a live count of the cycles still to run. The block turns the pulses into sticky status bits inside each channel's control word. It drops the channel's run bit when either pulse arrives. It merges every channel's enabled status into one interrupt line. Software finds the channel that raised the interrupt by reading the control words. It acknowledges a status bit by writing the control word back with that bit at zero.

Top module: `dma_csr_bank`

## Requirements
- R1: Channel c owns the byte window c*16 to c*16+15: word 0 is the source address, word 4 the destination address, word 8 the cycle count and word 12 the control word. All registers read zero after reset. Writes with address bits 1:0 not zero are ignored, and such reads return zero.
- R2: Source and destination registers hold all 32 written bits, read back as written, and appear unchanged on the per-channel engine outputs.
- R3: The cycle count is 24 bits wide and reads with bits 31:24 at zero. While the channel's run bit (control bit 0) is set, a read of the count returns the engine's live count instead of the stored value.
- R4: Control-word fields are: bit 0 run, bit 2 finish interrupt enable, bit 3 burst, bit 5 error interrupt enable, bit 6 source bus select, bit 7 destination bus select, bits 10:8 source step, bits 14:12 destination step, bits 19:16 destination request line, bits 21:20 data width, bits 27:24 source request line. All other bits read zero, so writing all ones reads back 0x0F3F77ED.
- R5: A finish pulse sets control bit 1 and an error pulse sets control bit 4. Both bits are sticky and no write can set them.
- R6: A control write with a status bit at 0 clears it. A 1 in that position leaves it unchanged.
- R7: A pulse arriving in the same cycle as a write that clears its status bit wins, and the bit ends set.
- R8: The run bit clears in the cycle after a finish or error pulse, even when a write in that same cycle sets it.
- R9: The interrupt output is high exactly when some channel has (bit 1 and bit 2) or (bit 4 and bit 5) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Register access valid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 6 | Byte address |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Read data for reqAddr, combinational |
| doneIn | input | 4 | Per-channel finish pulse from the engines |
| errIn | input | 4 | Per-channel error pulse from the engines |
| liveCount | input | 96 | Per-channel remaining cycle count, 24 bits each |
| srcAddrOut | output | 128 | Per-channel source address, 32 bits each |
| dstAddrOut | output | 128 | Per-channel destination address, 32 bits each |
| cycleOut | output | 96 | Per-channel programmed cycle count |
| ctrlOut | output | 128 | Per-channel control word |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a finish or error pulse landing in the very cycle a write clears its status bit or sets the run bit. The stimulus gets there by driving the write and the pulse at the same falling edge, so one rising edge sees both. The bench then reads the control word back. It repeats this on every channel, and it also runs interrupt cases with status set but the enable off, and with two channels raising status at once.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int CH_IDX_W = 4;
  localparam int CNT_W    = 24;
  localparam int WORD_W   = 32;

  localparam int BIT_RUN    = 0;
  localparam int BIT_FIN    = 1;
  localparam int BIT_FIN_IE = 2;
  localparam int BIT_ERR    = 4;
  localparam int BIT_ERR_IE = 5;

  // every implemented control bit, status included
  localparam logic [WORD_W-1:0] CTL_IMPL = 32'h0F3F_77FF;
  // bits copied straight from a write
  localparam logic [WORD_W-1:0] CTL_CFG  = CTL_IMPL &
    ~((32'd1 << BIT_RUN) | (32'd1 << BIT_FIN) | (32'd1 << BIT_ERR));

  typedef struct packed {
    logic                wrSrc;
    logic                wrDst;
    logic                wrCyc;
    logic                wrCtl;
    logic [CH_IDX_W-1:0] chan;
    logic [WORD_W-1:0]   data;
    logic                rdOk;
    logic [CH_IDX_W-1:0] rdChan;
    logic [1:0]          rdWord;
  } csrStrobe_t;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int NCH = 4,
  localparam int ADDR_W = $clog2(NCH) + 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output csrStrobe_t        strb
);
  logic aligned;
  logic wrHit;
  logic [CH_IDX_W-1:0] chanIdx;

  assign aligned = (reqAddr[1:0] == 2'b00);
  assign chanIdx = CH_IDX_W'(reqAddr[ADDR_W-1:4]);
  assign wrHit   = reqValid && reqWrite && aligned;

  always_comb begin
    strb        = '0;
    strb.chan   = chanIdx;
    strb.data   = reqWdata;
    strb.wrSrc  = wrHit && (reqAddr[3:2] == 2'd0);
    strb.wrDst  = wrHit && (reqAddr[3:2] == 2'd1);
    strb.wrCyc  = wrHit && (reqAddr[3:2] == 2'd2);
    strb.wrCtl  = wrHit && (reqAddr[3:2] == 2'd3);
    strb.rdOk   = aligned;
    strb.rdChan = chanIdx;
    strb.rdWord = reqAddr[3:2];
  end
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  csrStrobe_t              strb,
  input  logic [NCH-1:0]          doneIn,
  input  logic [NCH-1:0]          errIn,
  input  logic [NCH*CNT_W-1:0]    liveCount,
  output logic [NCH*WORD_W-1:0]   srcAddrOut,
  output logic [NCH*WORD_W-1:0]   dstAddrOut,
  output logic [NCH*CNT_W-1:0]    cycleOut,
  output logic [NCH*WORD_W-1:0]   ctrlOut,
  output logic [WORD_W-1:0]       rdData,
  output logic                    irq
);
  logic [WORD_W-1:0] chanRd  [NCH];
  logic [NCH-1:0]    chanIrq;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [WORD_W-1:0] srcQ, dstQ, ctlQ, ctlD;
    logic [CNT_W-1:0]  cycQ;
    logic hit, wrCtlHit, stop;

    assign hit      = (strb.chan == CH_IDX_W'(ch));
    assign wrCtlHit = strb.wrCtl && hit;
    assign stop     = doneIn[ch] || errIn[ch];

    always_comb begin
      ctlD = (wrCtlHit ? strb.data : ctlQ) & CTL_CFG;
      ctlD[BIT_RUN] = !stop && (wrCtlHit ? strb.data[BIT_RUN] : ctlQ[BIT_RUN]);
      ctlD[BIT_FIN] = doneIn[ch] ||
                      (ctlQ[BIT_FIN] && (!wrCtlHit || strb.data[BIT_FIN]));
      ctlD[BIT_ERR] = errIn[ch] ||
                      (ctlQ[BIT_ERR] && (!wrCtlHit || strb.data[BIT_ERR]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ <= '0;
        dstQ <= '0;
        cycQ <= '0;
        ctlQ <= '0;
      end else begin
        if (strb.wrSrc && hit) srcQ <= strb.data;
        if (strb.wrDst && hit) dstQ <= strb.data;
        if (strb.wrCyc && hit) cycQ <= strb.data[CNT_W-1:0];
        ctlQ <= ctlD;
      end
    end

    assign srcAddrOut[ch*WORD_W +: WORD_W] = srcQ;
    assign dstAddrOut[ch*WORD_W +: WORD_W] = dstQ;
    assign cycleOut[ch*CNT_W +: CNT_W]     = cycQ;
    assign ctrlOut[ch*WORD_W +: WORD_W]    = ctlQ;

    assign chanIrq[ch] = (ctlQ[BIT_FIN] && ctlQ[BIT_FIN_IE]) ||
                         (ctlQ[BIT_ERR] && ctlQ[BIT_ERR_IE]);

    always_comb begin
      chanRd[ch] = '0;
      if (strb.rdOk && (strb.rdChan == CH_IDX_W'(ch))) begin
        case (strb.rdWord)
          2'd0: chanRd[ch] = srcQ;
          2'd1: chanRd[ch] = dstQ;
          2'd2: chanRd[ch] = WORD_W'(ctlQ[BIT_RUN] ? liveCount[ch*CNT_W +: CNT_W] : cycQ);
          default: chanRd[ch] = ctlQ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NCH; i++) rdData = rdData | chanRd[i];
  end

  assign irq = |chanIrq;
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NCH = 4,
  localparam int ADDR_W = $clog2(NCH) + 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [31:0]           reqWdata,
  output logic [31:0]           rdData,
  input  logic [NCH-1:0]        doneIn,
  input  logic [NCH-1:0]        errIn,
  input  logic [NCH*24-1:0]     liveCount,
  output logic [NCH*32-1:0]     srcAddrOut,
  output logic [NCH*32-1:0]     dstAddrOut,
  output logic [NCH*24-1:0]     cycleOut,
  output logic [NCH*32-1:0]     ctrlOut,
  output logic                  irq
);
  csrStrobe_t strb;

  dma_csr_decode #(.NCH(NCH)) u_decode (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strb     (strb)
  );

  dma_csr_regs #(.NCH(NCH)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .doneIn     (doneIn),
    .errIn      (errIn),
    .liveCount  (liveCount),
    .srcAddrOut (srcAddrOut),
    .dstAddrOut (dstAddrOut),
    .cycleOut   (cycleOut),
    .ctrlOut    (ctrlOut),
    .rdData     (rdData),
    .irq        (irq)
  );
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
  parameter int NCH = 4,
  localparam int ADDR_W = $clog2(NCH) + 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       rdData,
  input logic [NCH-1:0]    doneIn,
  input logic [NCH-1:0]    errIn,
  input logic [NCH*24-1:0] liveCount,
  input logic [NCH*32-1:0] ctrlOut,
  input logic              irq
);
  logic expIrq;
  always_comb begin
    expIrq = 1'b0;
    for (int i = 0; i < NCH; i++)
      expIrq = expIrq || (ctrlOut[i*32+1] && ctrlOut[i*32+2]) ||
                         (ctrlOut[i*32+4] && ctrlOut[i*32+5]);
  end

  // R9
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == expIrq);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    // R4
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlOut[ch*32 +: 32] & ~32'h0F3F_77FF) == 32'd0);
    // R5
    fin_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ctrlOut[ch*32+1]) |-> $past(doneIn[ch]));
    // R5
    err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ctrlOut[ch*32+4]) |-> $past(errIn[ch]));
    // R7
    fin_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      doneIn[ch] |=> ctrlOut[ch*32+1]);
    // R7
    err_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      errIn[ch] |=> ctrlOut[ch*32+4]);
    // R8
    run_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (doneIn[ch] || errIn[ch]) |=> !ctrlOut[ch*32]);
    // R3
    live_read_chk: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && !reqWrite && reqAddr == ADDR_W'(ch*16+8) && ctrlOut[ch*32])
        |-> rdData == {8'd0, liveCount[ch*24 +: 24]});
  end
endmodule

bind dma_csr_bank dma_csr_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqAddr   (reqAddr),
  .rdData    (rdData),
  .doneIn    (doneIn),
  .errIn     (errIn),
  .liveCount (liveCount),
  .ctrlOut   (ctrlOut),
  .irq       (irq)
);

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [5:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rdData;
  logic [NCH-1:0] doneIn = '0;
  logic [NCH-1:0] errIn = '0;
  logic [NCH*24-1:0] liveCount = '0;
  logic [NCH*32-1:0] srcAddrOut, dstAddrOut, ctrlOut;
  logic [NCH*24-1:0] cycleOut;
  logic irq;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_csr_bank #(.NCH(NCH)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData),
    .doneIn(doneIn), .errIn(errIn), .liveCount(liveCount),
    .srcAddrOut(srcAddrOut), .dstAddrOut(dstAddrOut), .cycleOut(cycleOut),
    .ctrlOut(ctrlOut), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'(addr); reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 6'(addr);
    #1 d = rdData;
    reqValid = 1'b0;
  endtask

  task automatic pulse(input int ch, input bit isErr);
    @(negedge clk);
    if (isErr) errIn[ch] = 1'b1; else doneIn[ch] = 1'b1;
    @(negedge clk);
    doneIn = '0; errIn = '0;
  endtask

  // write and pulse meet at the same rising edge
  task automatic collide(input int ch, input bit isErr, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'(ch*16+12); reqWdata = d;
    if (isErr) errIn[ch] = 1'b1; else doneIn[ch] = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; doneIn = '0; errIn = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state on every word
    for (int a = 0; a < NCH*16; a += 4) begin
      rd(a, v); check("R1 reset", v, 32'd0);
    end
    check("R9 reset irq", {31'd0, irq}, 32'd0);

    // R1 R2 address map and data sweep
    for (int k = 0; k < 3; k++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        logic [31:0] ps, pd, pc;
        ps = 32'hA5A5_0000 ^ (ch << 4) ^ (k * 32'h1111_1111);
        pd = ~ps ^ (ch << 8);
        pc = 32'h0100_0000 * (k + 1) + ch * 32'h10101 + 7;
        wr(ch*16, ps); wr(ch*16+4, pd); wr(ch*16+8, pc);
      end
      for (int ch = 0; ch < NCH; ch++) begin
        logic [31:0] ps, pd, pc;
        ps = 32'hA5A5_0000 ^ (ch << 4) ^ (k * 32'h1111_1111);
        pd = ~ps ^ (ch << 8);
        pc = 32'h0100_0000 * (k + 1) + ch * 32'h10101 + 7;
        rd(ch*16, v);   check("R1 R2 src read", v, ps);
        rd(ch*16+4, v); check("R1 R2 dst read", v, pd);
        rd(ch*16+8, v); check("R3 cycle read", v, pc & 32'h00FF_FFFF);
        check("R2 src out", srcAddrOut[ch*32 +: 32], ps);
        check("R2 dst out", dstAddrOut[ch*32 +: 32], pd);
        check("R3 cycle out", {8'd0, cycleOut[ch*24 +: 24]}, pc & 32'h00FF_FFFF);
        rd(ch*16+2, v); check("R1 misaligned read", v, 32'd0);
      end
    end
    wr(1, 32'hDEAD_BEEF);
    rd(0, v); check("R1 misaligned write ignored", v, 32'hA5A5_0000 ^ 32'h2222_2222);

    for (int ch = 0; ch < NCH; ch++) begin
      int cw;
      cw = ch*16 + 12;
      // R4 layout
      wr(cw, 32'hFFFF_FFFF);
      rd(cw, v); check("R4 all ones", v, 32'h0F3F_77ED);
      check("R4 ctrl out", ctrlOut[ch*32 +: 32], 32'h0F3F_77ED);
      wr(cw, 32'h0);
      rd(cw, v); check("R4 all zero", v, 32'd0);

      // R3 live count
      liveCount[ch*24 +: 24] = 24'h12_3456 + 24'(ch * 24'h1001);
      wr(ch*16+8, 32'h0000_0100);
      wr(cw, 32'h1);
      rd(ch*16+8, v); check("R3 live while running", v, {8'd0, 24'h12_3456 + 24'(ch * 24'h1001)});
      wr(cw, 32'h0);
      rd(ch*16+8, v); check("R3 stored when idle", v, 32'h0000_0100);

      // R5 R8 R9 finish
      wr(cw, 32'h5);
      check("R9 no status irq", {31'd0, irq}, 32'd0);
      pulse(ch, 1'b0);
      rd(cw, v); check("R5 R8 finish sets, run drops", v, 32'h6);
      check("R9 finish irq", {31'd0, irq}, 32'd1);
      wr(cw, 32'h6);
      rd(cw, v); check("R6 write one keeps", v, 32'h6);
      wr(cw, 32'h4);
      rd(cw, v); check("R6 write zero clears", v, 32'h4);
      check("R9 irq cleared", {31'd0, irq}, 32'd0);
      wr(cw, 32'h6);
      rd(cw, v); check("R5 write cannot set", v, 32'h4);

      // R7 collision on finish
      wr(cw, 32'h6 | 32'h1);
      rd(cw, v); check("R5 still clear", v, 32'h5);
      collide(ch, 1'b0, 32'h1);
      rd(cw, v); check("R7 R8 pulse beats clear and run", v, 32'h2);

      // R5 R9 error, with finish enable off
      wr(cw, 32'h20);
      rd(cw, v); check("R6 clear finish", v, 32'h20);
      pulse(ch, 1'b1);
      rd(cw, v); check("R5 error sets", v, 32'h30);
      check("R9 error irq", {31'd0, irq}, 32'd1);
      collide(ch, 1'b1, 32'h21);
      rd(cw, v); check("R7 R8 error beats clear", v, 32'h30);
      wr(cw, 32'h0);
      rd(cw, v); check("R6 error cleared", v, 32'd0);

      // R9 status without enable
      pulse(ch, 1'b0);
      check("R9 status without enable", {31'd0, irq}, 32'd0);
      wr(cw, 32'h6);
      check("R9 enable raises irq", {31'd0, irq}, 32'd1);
      wr(cw, 32'h0);
    end

    // R9 two channels
    wr(12, 32'h4); wr(2*16+12, 32'h20);
    pulse(0, 1'b0); pulse(2, 1'b1);
    check("R9 two sources", {31'd0, irq}, 32'd1);
    wr(12, 32'h4);
    check("R9 one source left", {31'd0, irq}, 32'd1);
    wr(2*16+12, 32'h20);
    check("R9 none left", {31'd0, irq}, 32'd0);
    rd(2*16+12, v); check("R6 other channel", v, 32'h20);

    summary();
  end
endmodule